// File: doc/BRIEF.md
# External Bus Cycle Controller with Chip-Select Setup and Hold Expansion

This block runs one read or one write access on an external asynchronous memory bus. An internal requester presents an address, a direction bit and write data together with a one-clock start pulse. The block then owns the external pins for the whole access and returns a one-clock done pulse, plus the captured read data when the access was a read.

Every access is built from an ordinary two-cycle strobe window, T1 followed by T2. Two small configuration fields can stretch it. The setup field inserts Th cycles between chip-select assertion and the strobe. The hold field inserts Tf cycles between strobe release and chip-select release. During Th and Tf the chip select, address, direction line and DMA acknowledge stay active and the strobes stay off. On a write, the data bus keeps its value through the Tf cycles, which suits slow-write devices. Both fields are sampled on the start pulse. The polarity of the acknowledge output is chosen at elaboration.

Top module: `extbus_cs_ctrl`

## Requirements
- R1: Out of reset and while idle: chip select, read strobe and write strobe are high (inactive), the direction line is high, the acknowledge is inactive and done is low.
- R2: After an accepted start, chip select goes low for S leading cycles, where S is the 2-bit setup value sampled with the start (0 to 3). Both strobes stay high in those cycles.
- R3: After the setup cycles, the selected strobe is low for exactly two cycles with chip select low. The read strobe is used for reads and the write strobe for writes. The other strobe stays high.
- R4: After the strobe rises, chip select stays low for H more cycles, where H is the 2-bit hold value sampled with the start (0 to 3). Both strobes stay high in those cycles. Chip select then returns high.
- R5: The address and direction are latched at start and stay constant while chip select is low. The direction line is low for a write and high for a read.
- R6: On a write, the block drives the latched write data onto the data bus in every cycle that chip select is low, including all hold cycles.
- R7: On a read, the block releases the data bus and captures it on the clock edge that ends T2. The captured value appears on the read-data output no later than the done pulse and is held until the next read captures.
- R8: Done is high for exactly one clock, in the first cycle after the last chip-select-low cycle, and chip select is high in that cycle.
- R9: A start pulse that arrives while an access is in progress is ignored. It does not change the address, the direction, the write data or the length of the current access.
- R10: The acknowledge output is low during the access when the parameter DACK_ACTIVE_LOW is 1 and high when it is 0. It is inactive at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | 2 | Number of setup cycles (Th) |
| cfg_hold | input | 2 | Number of hold cycles (Tf) |
| rsp_rdata | output | DATA_W | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rnw | output | 1 | Direction, high for read |
| bus_dack | output | 1 | DMA acknowledge, polarity by parameter |
| bus_addr | output | ADDR_W | Latched address |
| bus_data | inout | DATA_W | Bidirectional data bus |

## Verification
The assertions assume only that the reset is applied before the first access. They also assume that a start may arrive in any cycle, including in the middle of an access. The setup and hold values are captured with the start, so the assertions make no assumption about the configuration inputs changing later. The stimulus drives the data bus from the device side only while the read strobe is low, so no assertion or check sees contention on a write. It also changes the request fields mid-access only in the directed test that checks that a late start is ignored.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

   localparam int CFG_W = 2;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_TH   = 3'd1,
      PH_T1   = 3'd2,
      PH_T2   = 3'd3,
      PH_TF   = 3'd4
   } phase_e;

endpackage

// File: rtl/extbus_phase_seq.sv
module extbus_phase_seq
   import extbus_pkg::*;
#(
   parameter int CNT_W = CFG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] setup_cnt,
   input  logic [CNT_W-1:0] hold_cnt,
   output phase_e           phase,
   output logic             accept,
   output logic             done
);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] hold_q;
   logic             done_q;

   assign accept = start && (phase_q == PH_IDLE);
   assign phase  = phase_q;
   assign done   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         hold_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (accept) begin
               hold_q <= hold_cnt;
               if (setup_cnt != '0) begin
                  phase_q <= PH_TH;
                  cnt_q   <= setup_cnt - 1'b1;
               end else begin
                  phase_q <= PH_T1;
               end
            end
            PH_TH: begin
               if (cnt_q == '0) phase_q <= PH_T1;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            PH_T1: phase_q <= PH_T2;
            PH_T2: begin
               if (hold_q != '0) begin
                  phase_q <= PH_TF;
                  cnt_q   <= hold_q - 1'b1;
               end else begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            end
            PH_TF: begin
               if (cnt_q == '0) begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   // R8: completion is a single-clock pulse
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R8: done only ever follows the end of an access
   p_done_after_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (phase_q == PH_IDLE));

endmodule

// File: rtl/extbus_pin_drv.sv
module extbus_pin_drv
   import extbus_pkg::*;
#(
   parameter int ADDR_W          = 26,
   parameter int DATA_W          = 32,
   parameter bit DACK_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              start,
   input  phase_e            phase,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] din,
   output logic              cs_n,
   output logic              rd_n,
   output logic              we_n,
   output logic              rnw,
   output logic              dack,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dout,
   output logic              oe,
   output logic [DATA_W-1:0] rdata
);

   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              active;
   logic              strobe;

   assign active = (phase != PH_IDLE);
   assign strobe = (phase == PH_T1) || (phase == PH_T2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (phase == PH_T2 && !wr_q) rdata_q <= din;
      end
   end

   assign cs_n  = !active;
   assign rd_n  = !(strobe && !wr_q);
   assign we_n  = !(strobe && wr_q);
   assign rnw   = active ? !wr_q : 1'b1;
   assign addr  = addr_q;
   assign dout  = wdata_q;
   assign oe    = active && wr_q;
   assign rdata = rdata_q;

   generate
      if (DACK_ACTIVE_LOW) begin : g_dack_low
         assign dack = !active;
      end else begin : g_dack_high
         assign dack = active;
      end
   endgenerate

   // R3: a strobe is only ever driven inside the chip-select window
   p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !we_n) |-> !cs_n);

   // R5: address and direction stay constant while selected
   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(rnw)));

   // R6: driven write data does not change during the access
   p_wdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && $past(oe)) |-> $stable(dout));

   // R9: a late start leaves the latched request untouched
   p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cs_n) |=> ($stable(addr) && $stable(dout)));

endmodule

// File: rtl/extbus_cs_ctrl.sv
module extbus_cs_ctrl
   import extbus_pkg::*;
#(
   parameter int ADDR_W          = 26,
   parameter int DATA_W          = 32,
   parameter bit DACK_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CFG_W-1:0]  cfg_setup,
   input  logic [CFG_W-1:0]  cfg_hold,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_we_n,
   output logic              bus_rnw,
   output logic              bus_dack,
   output logic [ADDR_W-1:0] bus_addr,
   inout  wire  [DATA_W-1:0] bus_data
);

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
         $error("extbus_cs_ctrl: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 128) begin : g_bad_data_w
         $error("extbus_cs_ctrl: DATA_W out of range");
      end
   endgenerate

   phase_e            phase;
   logic              accept;
   logic [DATA_W-1:0] dout;
   logic              oe;

   extbus_phase_seq #(.CNT_W(CFG_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req_start),
      .setup_cnt (cfg_setup),
      .hold_cnt  (cfg_hold),
      .phase     (phase),
      .accept    (accept),
      .done      (rsp_done)
   );

   extbus_pin_drv #(
      .ADDR_W          (ADDR_W),
      .DATA_W          (DATA_W),
      .DACK_ACTIVE_LOW (DACK_ACTIVE_LOW)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .start     (req_start),
      .phase     (phase),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .din       (bus_data),
      .cs_n      (bus_cs_n),
      .rd_n      (bus_rd_n),
      .we_n      (bus_we_n),
      .rnw       (bus_rnw),
      .dack      (bus_dack),
      .addr      (bus_addr),
      .dout      (dout),
      .oe        (oe),
      .rdata     (rsp_rdata)
   );

   assign bus_data = oe ? dout : {DATA_W{1'bz}};

   // R2 / R4: setup and hold cycles keep the select active, strobes off
   p_no_strobe_th_tf_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_TH) || (phase == PH_TF)) |-> (bus_rd_n && bus_we_n && !bus_cs_n));

   // R3: the strobe lasts exactly two cycles, T1 then T2
   p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T1) |=> (phase == PH_T2));

   // R1: idle pins are inactive
   p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (bus_cs_n && bus_rd_n && bus_we_n && bus_rnw));

endmodule

// File: tb/extbus_cs_ctrl_bench.sv
`timescale 1ns/1ps
module extbus_cs_ctrl_bench;

   localparam int AW = 26;
   localparam int DW = 32;
   localparam int VW = 4 + 1 + AW + DW + DW;

   // vector fields: setup(2) hold(2) write(1) addr wdata device-read-data
   localparam logic [VW-1:0] VEC [8] = '{
      {2'd0, 2'd0, 1'b1, 26'h0000123, 32'hA5A5_0001, 32'h0000_0000},
      {2'd0, 2'd0, 1'b0, 26'h0000456, 32'h0000_0000, 32'h1234_5678},
      {2'd1, 2'd0, 1'b1, 26'h1ABCDEF, 32'hDEAD_BEEF, 32'h0000_0000},
      {2'd0, 2'd1, 1'b0, 26'h0100000, 32'h0000_0000, 32'hCAFE_F00D},
      {2'd3, 2'd3, 1'b1, 26'h3FFFFFF, 32'hFFFF_0000, 32'h0000_0000},
      {2'd3, 2'd3, 1'b0, 26'h2000001, 32'h0000_0000, 32'h8000_0001},
      {2'd2, 2'd1, 1'b0, 26'h0ABCDE0, 32'h0000_0000, 32'h5A5A_5A5A},
      {2'd1, 2'd2, 1'b1, 26'h0000001, 32'h0F0F_0F0F, 32'h0000_0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    cfg_setup = '0;
   logic [1:0]    cfg_hold = '0;
   logic [DW-1:0] rsp_rdata, rsp_rdata2;
   logic          rsp_done, rsp_done2;
   logic          bus_cs_n, bus_rd_n, bus_we_n, bus_rnw, bus_dack;
   logic          cs2_n, rd2_n, we2_n, rnw2, dack2;
   logic [AW-1:0] bus_addr, addr2;
   wire  [DW-1:0] bus_data;
   wire  [DW-1:0] bus_data2;
   logic [DW-1:0] dev_val = '0;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   assign bus_data = !bus_rd_n ? dev_val : {DW{1'bz}};

   extbus_cs_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DACK_ACTIVE_LOW(1'b1)) u_extbus_cs_ctrl (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
      .cfg_hold(cfg_hold), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
      .bus_rnw(bus_rnw), .bus_dack(bus_dack), .bus_addr(bus_addr),
      .bus_data(bus_data)
   );

   extbus_cs_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DACK_ACTIVE_LOW(1'b0)) u_extbus_cs_ctrl_ahi (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
      .cfg_hold(cfg_hold), .rsp_rdata(rsp_rdata2), .rsp_done(rsp_done2),
      .bus_cs_n(cs2_n), .bus_rd_n(rd2_n), .bus_we_n(we2_n),
      .bus_rnw(rnw2), .bus_dack(dack2), .bus_addr(addr2),
      .bus_data(bus_data2)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_idle(input string tag);
      check(bus_cs_n == 1'b1, {"R1 cs_n ", tag}, 64'(bus_cs_n), 64'd1);
      check(bus_rd_n == 1'b1, {"R1 rd_n ", tag}, 64'(bus_rd_n), 64'd1);
      check(bus_we_n == 1'b1, {"R1 we_n ", tag}, 64'(bus_we_n), 64'd1);
      check(bus_rnw == 1'b1, {"R1 rnw ", tag}, 64'(bus_rnw), 64'd1);
      check(bus_dack == 1'b1, {"R1 dack ", tag}, 64'(bus_dack), 64'd1);
      check(dack2 == 1'b0, {"R10 dack active-high idle ", tag}, 64'(dack2), 64'd0);
   endtask

   // Run one access; inject = 1 fires a conflicting start mid-access (R9)
   task automatic run_access(input logic [1:0] s, input logic [1:0] h, input logic wr,
                             input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input logic [DW-1:0] rd, input bit inject);
      int len;
      len = int'(s) + 2 + int'(h);
      @(negedge clk);
      cfg_setup = s; cfg_hold = h; req_write = wr;
      req_addr = a; req_wdata = wd; dev_val = rd; req_start = 1'b1;
      for (int i = 0; i <= len; i++) begin
         @(negedge clk);
         if (i < len) begin
            bit strb;
            strb = (i == int'(s)) || (i == int'(s) + 1);
            check(bus_cs_n == 1'b0, "R2/R4 cs_n low in window", 64'(bus_cs_n), 64'd0);
            check(bus_rd_n == !(strb && !wr), "R2/R3/R4 rd_n", 64'(bus_rd_n),
                  64'(!(strb && !wr)));
            check(bus_we_n == !(strb && wr), "R2/R3/R4 we_n", 64'(bus_we_n),
                  64'(!(strb && wr)));
            check(bus_addr == a, "R5 address held", 64'(bus_addr), 64'(a));
            check(bus_rnw == !wr, "R5 direction", 64'(bus_rnw), 64'(!wr));
            check(bus_dack == 1'b0, "R10 dack active-low", 64'(bus_dack), 64'd0);
            check(dack2 == 1'b1, "R10 dack active-high", 64'(dack2), 64'd1);
            check(rsp_done == 1'b0, "R8 no early done", 64'(rsp_done), 64'd0);
            if (wr) check(bus_data == wd, "R6 write data driven", 64'(bus_data), 64'(wd));
         end else begin
            check(bus_cs_n == 1'b1, "R4/R8 cs_n released", 64'(bus_cs_n), 64'd1);
            check(rsp_done == 1'b1, "R8 done pulse", 64'(rsp_done), 64'd1);
            check(bus_rd_n && bus_we_n, "R4 strobes off", 64'({bus_rd_n, bus_we_n}), 64'd3);
            if (!wr) check(rsp_rdata == rd, "R7 read data", 64'(rsp_rdata), 64'(rd));
         end
         req_start = 1'b0;
         if (inject && i == 0) begin
            req_start = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
         end
      end
      @(negedge clk);
      check(rsp_done == 1'b0, "R8 done lasts one clock", 64'(rsp_done), 64'd0);
      check(bus_cs_n == 1'b1, "R9 no extra access", 64'(bus_cs_n), 64'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] held;
      repeat (3) @(negedge clk);
      check(rsp_done == 1'b0, "R1 done in reset", 64'(rsp_done), 64'd0);
      check_idle("in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("after reset");

      for (int v = 0; v < 8; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         run_access(e[VW-1 -: 2], e[VW-3 -: 2], e[VW-5], e[2*DW +: AW],
                    e[DW +: DW], e[0 +: DW], 1'b0);
         check_idle("between accesses");
      end

      // R9: conflicting start during a stretched read
      run_access(2'd2, 2'd2, 1'b0, 26'h0155555, 32'h0, 32'h1357_9BDF, 1'b1);
      // R9: conflicting start during a stretched write
      run_access(2'd3, 2'd1, 1'b1, 26'h02AAAAA, 32'h2468_ACE0, 32'h0, 1'b1);

      // R7: read data persists across a following write
      held = rsp_rdata;
      run_access(2'd0, 2'd0, 1'b1, 26'h0000077, 32'h7777_7777, 32'h0, 1'b0);
      check(rsp_rdata == held, "R7 read data held over write", 64'(rsp_rdata), 64'(held));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule